// File: doc/BRIEF.md
# Masked Internal Register File

This block holds the privileged control registers of a processor core and gives them one index-addressed access port. A single index selects the register; a read strobe and a write strobe may be raised alone or together in the same cycle. Every register has its own class of access and its own write mask. Some registers take only certain bits of the write data. Some are cleared by any write. Some may only be read, some may only be written, and some indices hold nothing at all.

A cycle-counter register keeps a software-written upper half. When it is read, that upper half is returned together with the low half of a free-running hardware count. Writes that would start a translation-buffer insert or flush are accepted and produce no fault, but have no further effect here. Read data and the fault flag are registered, so both appear one clock after the strobe. A read and a write to the same index in one cycle return the value held before the write.

Top module: `ipr_file`

## Requirements
- R1: After reset every stored register reads zero, except the base register (index 8), which reads the BASE_RST parameter, and the scratch slot CPU_SLOT (indices 0..7 are scratch), which reads the CPU_ID parameter. The outputs are zero during and right after reset.
- R2: Read data and fault are registered and appear one cycle after the strobe. A cycle with no strobe gives zero read data and no fault. A successful access gives fault 0.
- R3: The eight scratch registers (indices 0..7) and the base register (8) store all 64 bits of the write data.
- R4: Masked registers store `wdata & mask`: AST request 10 and AST enable 11 use 0xf, priority level 12 uses 0x1f, current mode 13 uses 0x18, software interrupt request 15 uses 0x7fff0, cache mode 16 and miss mode 17 use 0x3f, cache test 18 uses 0x1ffb, and instruction address-space number 19 uses 0x7f0.
- R5: The cycle counter (index 9) stores a full write. Its read data takes bits 63:32 from the stored value and bits 31:0 from the live count.
- R6: A write of any value to exception summary (20) or exception mask (21) leaves it at zero.
- R7: A write to a read-only register (interrupt ID 22, memory-management status 23, temporary page-table entry 24) raises fault and changes nothing. Reads of these registers return their value without fault.
- R8: A read of a write-only register (alternate mode 14, interrupt clear 25, serial transmit 26, data-cache flush 27, instruction-cache flush 28, buffer invalidate 29) raises fault and returns zero. A write to one of them raises no fault. Alternate mode keeps `wdata & 0x18`.
- R9: Any access to an unlisted index (30..63) raises fault, returns zero and writes nothing.
- R10: A read and a write to the same index in one cycle return the old value. The new value is visible to the next read.
- R11: The low 32 bits of the cycle-counter read rise by exactly one per clock between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| idx | input | 6 | Register index for the read and the write |
| wr_en | input | 1 | Write strobe |
| wdata | input | 64 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 64 | Read result, one cycle after rd_en |
| fault | output | 1 | Illegal access, one cycle after the strobe |

## Verification
Every strobe is applied across exactly one rising edge. Its read data and fault are sampled at the following falling edge, which is the first point where the registered result is valid. A write takes effect at that same edge, so a read issued on the next cycle sees the new value, while a read in the same cycle as the write sees the old one. The live count is checked only as differences between reads: reads issued k cycles apart must differ by k in their low half. This removes any dependence on how many cycles reset lasted.

// File: rtl/ipr_pkg.sv
package ipr_pkg;
    localparam int REG_W  = 64;
    localparam int HALF_W = REG_W / 2;
    localparam int IW     = 6;
    localparam int NSLOT  = 1 << IW;
    localparam int NSCR   = 8;

    localparam logic [IW-1:0] IX_BASE    = 6'd8;
    localparam logic [IW-1:0] IX_CYC     = 6'd9;
    localparam logic [IW-1:0] IX_ASTREQ  = 6'd10;
    localparam logic [IW-1:0] IX_ASTEN   = 6'd11;
    localparam logic [IW-1:0] IX_PLEVEL  = 6'd12;
    localparam logic [IW-1:0] IX_CURMODE = 6'd13;
    localparam logic [IW-1:0] IX_ALTMODE = 6'd14;
    localparam logic [IW-1:0] IX_SWINT   = 6'd15;
    localparam logic [IW-1:0] IX_CMODE   = 6'd16;
    localparam logic [IW-1:0] IX_MMODE   = 6'd17;
    localparam logic [IW-1:0] IX_CTEST   = 6'd18;
    localparam logic [IW-1:0] IX_IASN    = 6'd19;
    localparam logic [IW-1:0] IX_EXCSUM  = 6'd20;
    localparam logic [IW-1:0] IX_EXCMSK  = 6'd21;
    localparam logic [IW-1:0] IX_INTID   = 6'd22;
    localparam logic [IW-1:0] IX_MMSTAT  = 6'd23;
    localparam logic [IW-1:0] IX_PTETMP  = 6'd24;
    localparam logic [IW-1:0] IX_INTCLR  = 6'd25;
    localparam logic [IW-1:0] IX_SERTX   = 6'd26;
    localparam logic [IW-1:0] IX_DFLUSH  = 6'd27;
    localparam logic [IW-1:0] IX_IFLUSH  = 6'd28;
    localparam logic [IW-1:0] IX_BINVAL  = 6'd29;
    localparam logic [IW-1:0] IX_LAST    = IX_BINVAL;

    typedef struct packed {
        logic             rd_ok;
        logic             wr_ok;
        logic             keep;
        logic             wipe;
        logic             cyc;
        logic [REG_W-1:0] mask;
    } attr_t;

    typedef struct packed {
        logic [NSLOT-1:0][REG_W-1:0] regs;
        logic [REG_W-1:0]            rdata;
        logic                        fault;
    } state_t;
endpackage

// File: rtl/ipr_decode.sv
module ipr_decode
    import ipr_pkg::*;
(
    input  logic [IW-1:0] idx,
    output attr_t         attr
);
    localparam logic [REG_W-1:0] ALL1 = {REG_W{1'b1}};

    function automatic attr_t mk(input logic r, input logic w, input logic k,
                                 input logic z, input logic c,
                                 input logic [REG_W-1:0] m);
        attr_t a;
        a.rd_ok = r;
        a.wr_ok = w;
        a.keep  = k;
        a.wipe  = z;
        a.cyc   = c;
        a.mask  = m;
        return a;
    endfunction

    always_comb begin
        attr = mk(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
        if (idx < IW'(NSCR)) begin
            attr = mk(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, ALL1);
        end else begin
            case (idx)
                IX_BASE:    attr = mk(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, ALL1);
                IX_CYC:     attr = mk(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, ALL1);
                IX_ASTREQ,
                IX_ASTEN:   attr = mk(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, REG_W'(64'hf));
                IX_PLEVEL:  attr = mk(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, REG_W'(64'h1f));
                IX_CURMODE: attr = mk(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, REG_W'(64'h18));
                IX_ALTMODE: attr = mk(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, REG_W'(64'h18));
                IX_SWINT:   attr = mk(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, REG_W'(64'h7fff0));
                IX_CMODE,
                IX_MMODE:   attr = mk(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, REG_W'(64'h3f));
                IX_CTEST:   attr = mk(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, REG_W'(64'h1ffb));
                IX_IASN:    attr = mk(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, REG_W'(64'h7f0));
                IX_EXCSUM,
                IX_EXCMSK:  attr = mk(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, '0);
                IX_INTID,
                IX_MMSTAT,
                IX_PTETMP:  attr = mk(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0);
                IX_INTCLR,
                IX_SERTX,
                IX_DFLUSH,
                IX_IFLUSH,
                IX_BINVAL:  attr = mk(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0);
                default:    attr = mk(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
            endcase
        end
    end
endmodule

// File: rtl/ipr_cycle_ctr.sv
module ipr_cycle_ctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] count
);
    logic [W-1:0] count_d, count_q;

    always_comb count_d = count_q + W'(1);

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count_d;
    end

    assign count = count_q;
endmodule

// File: rtl/ipr_file.sv
module ipr_file
    import ipr_pkg::*;
#(
    parameter logic [REG_W-1:0] BASE_RST = 64'h0000_0000_0040_0000,
    parameter logic [REG_W-1:0] CPU_ID   = 64'd3,
    parameter int               CPU_SLOT = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IW-1:0]    idx,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             rd_en,
    output logic [REG_W-1:0] rd_data,
    output logic             fault
);
    attr_t             attr;
    logic [HALF_W-1:0] live;
    state_t            st_d, st_q;

    ipr_decode u_dec (.idx(idx), .attr(attr));

    ipr_cycle_ctr #(.W(HALF_W)) u_cyc (.clk(clk), .rst(rst), .count(live));

    function automatic state_t reset_state();
        state_t s;
        s = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (i == CPU_SLOT)   s.regs[i] = CPU_ID;
            if (i == int'(IX_BASE)) s.regs[i] = BASE_RST;
        end
        return s;
    endfunction

    always_comb begin
        logic [REG_W-1:0] cur;
        st_d = st_q;
        cur  = st_q.regs[idx];
        if (wr_en && attr.wr_ok && attr.keep)
            st_d.regs[idx] = attr.wipe ? '0 : (wdata & attr.mask);
        if (rd_en && attr.rd_ok)
            st_d.rdata = attr.cyc ? {cur[REG_W-1:HALF_W], live} : cur;
        else
            st_d.rdata = '0;
        st_d.fault = (rd_en && !attr.rd_ok) || (wr_en && !attr.wr_ok);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= reset_state();
        else     st_q <= st_d;
    end

    assign rd_data = st_q.rdata;
    assign fault   = st_q.fault;
endmodule

// File: rtl/ipr_file_chk.sv
module ipr_file_chk
    import ipr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [IW-1:0]    idx,
    input logic             wr_en,
    input logic             rd_en,
    input logic [REG_W-1:0] rd_data,
    input logic             fault
);
    logic wo_hit, ro_hit, unl_hit;
    assign wo_hit  = (idx == IX_ALTMODE) || (idx >= IX_INTCLR && idx <= IX_BINVAL);
    assign ro_hit  = (idx >= IX_INTID && idx <= IX_PTETMP);
    assign unl_hit = (idx > IX_LAST);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (!rd_en && !wr_en) |=> (!fault && rd_data == '0));

    p_unlisted_r9: assert property (@(posedge clk) disable iff (rst)
        ((rd_en || wr_en) && unl_hit) |=> (fault && rd_data == '0));

    p_wo_read_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && wo_hit) |=> (fault && rd_data == '0));

    p_ro_write_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ro_hit) |=> fault);

    p_plevel_mask_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && idx == IX_PLEVEL) |=> (rd_data[REG_W-1:5] == '0));

    p_cyc_step_r11: assert property (@(posedge clk) disable iff (rst)
        (rd_en && idx == IX_CYC) ##1 (rd_en && idx == IX_CYC) |=>
        (rd_data[HALF_W-1:0] == HALF_W'($past(rd_data[HALF_W-1:0]) + 1)));
endmodule

bind ipr_file ipr_file_chk u_chk (
    .clk(clk), .rst(rst), .idx(idx), .wr_en(wr_en), .rd_en(rd_en),
    .rd_data(rd_data), .fault(fault)
);

// File: tb/ipr_file_test.sv
module ipr_file_test;
    localparam logic [63:0] BASE_V = 64'h0000_0000_0040_0000;
    localparam logic [63:0] CPU_V  = 64'd3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  idx = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [63:0] wdata = '0;
    logic [63:0] rd_data;
    logic        fault;

    int total = 0, bad = 0;
    bit finished = 0;
    logic [63:0] mir [64];

    ipr_file uut (.clk(clk), .rst(rst), .idx(idx), .wr_en(wr_en), .wdata(wdata),
                  .rd_en(rd_en), .rd_data(rd_data), .fault(fault));

    always #5 clk = ~clk;

    function automatic bit can_rd(input int i);
        return (i < 30) && !(i == 14 || i >= 25);
    endfunction
    function automatic bit can_wr(input int i);
        return (i < 30) && !(i >= 22 && i <= 24);
    endfunction
    function automatic bit keeps(input int i);
        return (i <= 21) || (i == 14);
    endfunction
    function automatic logic [63:0] mask_of(input int i);
        case (i)
            10, 11:  return 64'hf;
            12:      return 64'h1f;
            13, 14:  return 64'h18;
            15:      return 64'h7fff0;
            16, 17:  return 64'h3f;
            18:      return 64'h1ffb;
            19:      return 64'h7f0;
            20, 21:  return 64'h0;
            default: return '1;
        endcase
    endfunction
    function automatic string tag_of(input int i);
        if (i <= 8) return "R3";
        if (i == 9) return "R5";
        if (i == 14 || (i >= 25 && i <= 29)) return "R8";
        if (i <= 19) return "R4";
        if (i <= 21) return "R6";
        if (i <= 24) return "R7";
        return "R9";
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic op(input logic r, input logic w, input int i, input logic [63:0] d);
        rd_en = r; wr_en = w; idx = 6'(i); wdata = d;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
    endtask

    task automatic read_check(input int i, input string req);
        logic [63:0] e;
        op(1'b1, 1'b0, i, '0);
        e = can_rd(i) ? mir[i] : 64'd0;
        if (i == 9) check(req, {rd_data[63:32], 32'd0}, {e[63:32], 32'd0});
        else        check(req, rd_data, e);
        check(req, 64'(fault), 64'(!can_rd(i)));
    endtask

    task automatic write_check(input int i, input logic [63:0] d);
        op(1'b0, 1'b1, i, d);
        check(tag_of(i), 64'(fault), 64'(!can_wr(i)));
        check("R2", rd_data, 64'd0);
        if (can_wr(i) && keeps(i)) mir[i] = (i == 20 || i == 21) ? 64'd0 : (d & mask_of(i));
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mir[i] = '0;
        mir[0] = CPU_V;
        mir[8] = BASE_V;
        repeat (3) @(negedge clk);
        check("R1", rd_data, 64'd0);
        check("R1", 64'(fault), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R2", {63'd0, fault}, 64'd0);
        for (int i = 0; i < 64; i++) read_check(i, "R1");
        for (int i = 0; i < 64; i++) begin
            write_check(i, '1);
            read_check(i, tag_of(i));
            write_check(i, 64'hA5A5_5A5A_F0F0_0F0F ^ 64'(i * 64'h0101_0101));
            read_check(i, tag_of(i));
        end
        for (int i = 0; i < 64; i++) read_check(i, "R9");
        write_check(3, 64'h1111_2222_3333_4444);
        op(1'b1, 1'b1, 3, 64'h9999_8888_7777_6666);
        check("R10", rd_data, 64'h1111_2222_3333_4444);
        check("R10", 64'(fault), 64'd0);
        mir[3] = 64'h9999_8888_7777_6666;
        read_check(3, "R10");
        write_check(9, 64'hDEAD_BEEF_0000_0000);
        begin
            logic [31:0] a, b, c;
            op(1'b1, 1'b0, 9, '0); a = rd_data[31:0];
            check("R5", {32'd0, rd_data[63:32]}, 64'h0000_0000_DEAD_BEEF);
            op(1'b1, 1'b0, 9, '0); b = rd_data[31:0];
            check("R11", 64'(b - a), 64'd1);
            repeat (5) op(1'b0, 1'b0, 0, '0);
            op(1'b1, 1'b0, 9, '0); c = rd_data[31:0];
            check("R11", 64'(c - b), 64'd6);
        end
        op(1'b0, 1'b0, 0, '0);
        check("R2", rd_data, 64'd0);
        check("R2", 64'(fault), 64'd0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=running exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule